// File: doc/BRIEF.md
# Weighted Clean-Decision Pattern Compressor

This block watches a serial stream of yes/no cleaning decisions, one per execution of a single store, and condenses it into a short repeating bit pattern. Stream bit n goes to pattern position n modulo K. For each position the block keeps a count of the ones and a count of the zeros it has seen. When the stream ends, each position is settled by comparing two weighted costs. Choosing 0 misses a needed clean, and that costs the number of ones times `W_MISS`. Choosing 1 cleans when no clean was needed, and that costs the number of zeros times `W_CLEAN`.

The block is driven by a small state machine. The states are ST_IDLE (after reset, stream ignored), ST_COLLECT (bits are tallied), ST_DECIDE (a one-cycle step in which the costs are compared) and ST_HOLD (the result is presented). The transitions are: any state to ST_COLLECT on `start_i`; ST_COLLECT to ST_DECIDE on `end_i`; ST_DECIDE to ST_HOLD unconditionally; ST_IDLE and ST_HOLD stay where they are until `start_i`. Any state not named in these transitions stays put.

Top module: `weighted_pattern_compressor`

## Requirements
- R1: After reset `done_o` is 0, `pattern_o` is all zeros, and bits or `end_i` presented before the first `start_i` have no effect.
- R2: `start_i` sampled high clears all counts, the position index, `pattern_o` and `done_o` by the next cycle, from any state. A `bit_valid_i` in the same cycle as `start_i` is not counted.
- R3: The n-th valid bit after a start (counting from 0) is tallied to position n mod K, and position p drives `pattern_o[p]`.
- R4: A position's bit is 1 when it has at least one 1 and zeros×W_CLEAN ≤ ones×W_MISS (defaults W_MISS=1, W_CLEAN=2). Otherwise the bit is 0. A tie gives 1.
- R5: A position that received only zeros, or no bits at all (for example a stream shorter than K), yields 0.
- R6: If `end_i` is sampled at clock edge t while collecting, `done_o` is still 0 after edge t and becomes 1, with the final `pattern_o`, after edge t+1. A valid bit presented together with `end_i` is counted.
- R7: Once `done_o` is 1, `done_o` and `pattern_o` hold until `start_i`. `bit_valid_i` and `end_i` have no effect while holding.
- R8: Each count saturates at 2^CW−1, where CW = $clog2(MAX_LEN+1). The decision uses the saturated values.
- R9: Cycles with `bit_valid_i` low while collecting neither count a bit nor advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clears state and begins a new stream |
| bit_valid_i | input | 1 | Qualifies `bit_i` this cycle |
| bit_i | input | 1 | Decision bit: 1 = clean, 0 = no clean |
| end_i | input | 1 | Marks the end of the stream |
| pattern_o | output | K | Compressed pattern; bit p is position p |
| done_o | output | 1 | Pattern valid and held |

## Verification
The cost rule is tried with rounds that give different positions clear majorities of ones, clear majorities of zeros, exact 2:1 ties and 1:1 splits. This separates a weighted comparison from a plain majority vote and shows which way ties go. A three-bit stream that ends together with its last bit checks the position mapping, the untouched-position default and the counting of a bit that arrives with `end_i`. Streams with idle gaps, traffic sent while idle or holding, and a restart in mid-stream show what must be ignored. A stream long enough to saturate one position's ones count, while the unsaturated answer would differ, shows that the decision uses the saturated value.

// File: rtl/wkc_pkg.sv
package wkc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DECIDE  = 2'd2,
        ST_HOLD    = 2'd3
    } wkc_state_e;
endpackage

// File: rtl/wkc_ctrl.sv
module wkc_ctrl
    import wkc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       end_i,
    output wkc_state_e state_o,
    output logic       clear_o,
    output logic       accept_o,
    output logic       load_o
);
    wkc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_COLLECT: if (end_i) state_d = ST_DECIDE;
                ST_DECIDE:  state_d = ST_HOLD;
                ST_HOLD:    state_d = ST_HOLD;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        state_o  = state_q;
        clear_o  = start_i;
        accept_o = (state_q == ST_COLLECT) && !start_i;
        load_o   = (state_q == ST_DECIDE) && !start_i;
    end
endmodule

// File: rtl/wkc_tally.sv
module wkc_tally #(
    parameter int K  = 8,
    parameter int CW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                accept_i,
    input  logic                valid_i,
    input  logic                bit_i,
    output logic [K-1:0][CW-1:0] ones_o,
    output logic [K-1:0][CW-1:0] zeros_o
);
    localparam int          IDX_W = (K > 1) ? $clog2(K) : 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [IDX_W-1:0] idx_q;
    logic             take;

    assign take = accept_i && valid_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          idx_q <= '0;
        else if (clear_i)    idx_q <= '0;
        else if (take) begin
            if (idx_q == IDX_W'(K - 1)) idx_q <= '0;
            else                        idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar p = 0; p < K; p++) begin : g_pos
        logic hit;
        assign hit = take && (idx_q == IDX_W'(p));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ones_o[p]  <= '0;
                zeros_o[p] <= '0;
            end else if (clear_i) begin
                ones_o[p]  <= '0;
                zeros_o[p] <= '0;
            end else if (hit) begin
                if (bit_i && ones_o[p] != CMAX)   ones_o[p]  <= ones_o[p] + 1'b1;
                if (!bit_i && zeros_o[p] != CMAX) zeros_o[p] <= zeros_o[p] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wkc_pick.sv
module wkc_pick #(
    parameter int K       = 8,
    parameter int CW      = 10,
    parameter int WGT_W   = 4,
    parameter int W_MISS  = 1,
    parameter int W_CLEAN = 2
) (
    input  logic [K-1:0][CW-1:0] ones_i,
    input  logic [K-1:0][CW-1:0] zeros_i,
    output logic [K-1:0]         pick_o
);
    localparam int CST_W = CW + WGT_W;
    localparam logic [CST_W-1:0] WM = CST_W'(W_MISS);
    localparam logic [CST_W-1:0] WC = CST_W'(W_CLEAN);

    for (genvar p = 0; p < K; p++) begin : g_pick
        logic [CST_W-1:0] cost_zero;
        logic [CST_W-1:0] cost_one;
        assign cost_zero = CST_W'(ones_i[p]) * WM;
        assign cost_one  = CST_W'(zeros_i[p]) * WC;
        assign pick_o[p] = (ones_i[p] != '0) && (cost_one <= cost_zero);
    end
endmodule

// File: rtl/weighted_pattern_compressor.sv
module weighted_pattern_compressor
    import wkc_pkg::*;
#(
    parameter int K       = 8,
    parameter int MAX_LEN = 1023,
    parameter int WGT_W   = 4,
    parameter int W_MISS  = 1,
    parameter int W_CLEAN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         bit_valid_i,
    input  logic         bit_i,
    input  logic         end_i,
    output logic [K-1:0] pattern_o,
    output logic         done_o
);
    localparam int CW = $clog2(MAX_LEN + 1);

    wkc_state_e           st;
    logic                 clr, acc, load;
    logic [K-1:0][CW-1:0] ones, zeros;
    logic [K-1:0]         pick;

    wkc_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .end_i    (end_i),
        .state_o  (st),
        .clear_o  (clr),
        .accept_o (acc),
        .load_o   (load)
    );

    wkc_tally #(.K(K), .CW(CW)) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (clr),
        .accept_i (acc),
        .valid_i  (bit_valid_i),
        .bit_i    (bit_i),
        .ones_o   (ones),
        .zeros_o  (zeros)
    );

    wkc_pick #(.K(K), .CW(CW), .WGT_W(WGT_W), .W_MISS(W_MISS), .W_CLEAN(W_CLEAN)) u_pick (
        .ones_i  (ones),
        .zeros_i (zeros),
        .pick_o  (pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pattern_o <= '0;
            done_o    <= 1'b0;
        end else if (clr) begin
            pattern_o <= '0;
            done_o    <= 1'b0;
        end else if (load) begin
            pattern_o <= pick;
            done_o    <= 1'b1;
        end
    end
endmodule

// File: rtl/wkc_checker.sv
module wkc_checker
    import wkc_pkg::*;
#(
    parameter int K = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         end_i,
    input logic [K-1:0] pattern_o,
    input logic         done_o,
    input wkc_state_e   state
);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && pattern_o == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pattern_o)));

    assert_done_after_decide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state == ST_DECIDE));

    assert_end_to_decide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && end_i && !start_i) |=> (state == ST_DECIDE && !done_o));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!done_o && pattern_o == '0));
endmodule

bind weighted_pattern_compressor wkc_checker #(.K(K)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .end_i     (end_i),
    .pattern_o (pattern_o),
    .done_o    (done_o),
    .state     (st)
);

// File: tb/weighted_pattern_compressor_tb.sv
module weighted_pattern_compressor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int K    = 8;
    localparam int CMAX = 1023;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, bit_valid_i = 1'b0, bit_i = 1'b0, end_i = 1'b0;
    logic [K-1:0] pattern_o;
    logic done_o;

    int n_chk = 0;
    int n_fail = 0;
    int mo[K];
    int mz[K];
    int midx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    weighted_pattern_compressor u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_valid_i(bit_valid_i),
        .bit_i(bit_i), .end_i(end_i), .pattern_o(pattern_o), .done_o(done_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < K; p++) begin mo[p] = 0; mz[p] = 0; end
        midx = 0;
    endtask

    task automatic model_bit(input logic b);
        if (b) begin if (mo[midx] < CMAX) mo[midx]++; end
        else   begin if (mz[midx] < CMAX) mz[midx]++; end
        midx = (midx + 1) % K;
    endtask

    function automatic int model_pattern();
        int r = 0;
        for (int p = 0; p < K; p++)
            if (mo[p] > 0 && mz[p] * 2 <= mo[p]) r |= (1 << p);
        return r;
    endfunction

    task automatic drive(input logic v, input logic b, input logic e, input logic s);
        @(negedge clk);
        bit_valid_i = v; bit_i = b; end_i = e; start_i = s;
    endtask

    task automatic do_start();
        drive(0, 0, 0, 1);
        drive(0, 0, 0, 0);
        model_clear();
    endtask

    task automatic send(input logic b);
        drive(1, b, 0, 0);
        model_bit(b);
    endtask

    task automatic send_word(input logic [K-1:0] w);
        for (int i = 0; i < K; i++) send(w[i]);
    endtask

    task automatic finish_and_check(input string tag);
        drive(0, 0, 1, 0);
        drive(0, 0, 0, 0);
        check({tag, " R6 done not early"}, int'(done_o), 0);
        drive(0, 0, 0, 0);
        check({tag, " R6 done"}, int'(done_o), 1);
        check({tag, " pattern"}, int'(pattern_o), model_pattern());
    endtask

    task automatic t_reset();
        check("R1 reset done", int'(done_o), 0);
        check("R1 reset pattern", int'(pattern_o), 0);
        send(1); send(1); drive(0, 0, 1, 0); drive(0, 0, 0, 0); drive(0, 0, 0, 0);
        check("R1 idle ignores stream done", int'(done_o), 0);
        check("R1 idle ignores stream pattern", int'(pattern_o), 0);
    endtask

    task automatic t_costs();
        do_start();
        send_word(8'b1101_0101); send_word(8'b0101_1101);
        send_word(8'b1111_0100); send_word(8'b0100_0101);
        finish_and_check("R4 R3 weighted mix");
        check("R4 mix literal", int'(pattern_o), 8'h05 | 8'h04 | 8'h40 | 8'h10);
    endtask

    task automatic t_tie();
        do_start();
        send_word(8'hFF); send_word(8'h00); send_word(8'hFF);
        finish_and_check("R4 tie");
        check("R4 tie favours clean", int'(pattern_o), 8'hFF);
        do_start();
        send_word(8'hF0); send_word(8'h0F);
        finish_and_check("R4 one-one split");
        check("R4 one-one gives zero", int'(pattern_o), 8'h00);
    endtask

    task automatic t_short();
        do_start();
        send(1); send(0);
        drive(1, 1, 1, 0); model_bit(1);
        drive(0, 0, 0, 0);
        check("R6 short done not early", int'(done_o), 0);
        drive(0, 0, 0, 0);
        check("R5 R6 short done", int'(done_o), 1);
        check("R5 R3 short pattern", int'(pattern_o), 8'h05);
    endtask

    task automatic t_gaps();
        do_start();
        send(1);
        drive(0, 1, 0, 0); drive(0, 1, 0, 0);
        send(0);
        drive(0, 1, 0, 0);
        send(1);
        finish_and_check("R9 gaps");
        check("R9 gaps literal", int'(pattern_o), 8'h05);
    endtask

    task automatic t_hold();
        logic [K-1:0] held;
        held = pattern_o;
        send_word(8'hFA); drive(0, 0, 1, 0); drive(0, 0, 0, 0);
        drive(0, 0, 0, 0); drive(0, 0, 0, 0);
        model_clear();
        check("R7 hold done", int'(done_o), 1);
        check("R7 hold pattern", int'(pattern_o), int'(held));
    endtask

    task automatic t_restart();
        do_start();
        send_word(8'hFF); send_word(8'hFF);
        drive(1, 1, 0, 1);
        drive(0, 0, 0, 0);
        model_clear();
        check("R2 start clears done", int'(done_o), 0);
        send_word(8'h30);
        finish_and_check("R2 restart");
        check("R2 restart literal", int'(pattern_o), 8'h30);
    endtask

    task automatic t_sat();
        do_start();
        for (int j = 0; j < 1620; j++)
            for (int p = 0; p < K; p++)
                send(p == 0 ? (j < 1100) : (j % 3 == 0));
        finish_and_check("R8 saturation");
        check("R8 saturated bit0 is zero", int'(pattern_o[0]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_costs();
        t_tie();
        t_short();
        t_gaps();
        t_hold();
        t_restart();
        t_sat();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule